// File: doc/BRIEF.md
# Three-Phase Gate Interlock and Fault Logic

This block sits between the PWM controller and the gate-drive enables of a three-phase inverter with a brake switch. Each phase has an upper and a lower command input, and the brake has one. All command inputs are active-low. The block passes the commands through to active-high gate enables. Along the way it enforces three protections: it blocks arm shoot-through, it shuts down any switch that reports a short circuit, and it raises a current-limit warning.

Every raw input first passes through a two-flop synchronizer, and all timing is counted in clock cycles. A phase whose two commands are both on is turned fully off. That state is latched until the later of the two commands makes a fresh turn-on edge. A short-circuit flag turns off only its own switch, and that shutdown ends on the switch's next turn-on command. The fault and warning outputs are active-low drive enables for open-drain pads.

Top module: `inverter_guard`

## Requirements
- R1: A low level on a synchronized command input turns its gate enable on, and a high level turns it off. The brake gate follows `brk_cmd_n` in the same way. Bit p of `hi_cmd_n`/`lo_cmd_n` belongs to phase p.
- R2: When both commands of one phase are on, both gates of that phase are off in the same cycle that the pair is first seen. The fault output is low in that cycle too. The two gates of a phase are never on together.
- R3: After an interlock, both gates of that phase stay off and the fault stays low, even when one or both commands are released.
- R4: A latched interlock clears only when each of the two commands of that phase has made a new high-to-low transition since the latch was set. It clears on the later of these two transitions, and the gates follow one cycle later.
- R5: A set `sc_flag` bit while its switch is commanded on turns off only that switch and pulls the fault output low. Bits [P-1:0] of `sc_flag` belong to the upper switches and bits [2P-1:P] to the lower switches. The brake gate is never affected.
- R6: A short-circuit shutdown holds after the flag drops and after the command is released. It clears on the next high-to-low transition of that switch's command, if the flag is low at that time.
- R7: `warn_n` goes low one cycle after `ilim_flag` is seen while any inverter gate is on. When no inverter gate is on, `ilim_flag` is ignored.
- R8: Once low, `warn_n` holds until a high-to-low transition on any inverter command input, with `ilim_flag` low at that time. Releasing a command does not clear it.
- R9: A command change at the input pins appears on the gate enables after exactly two rising clock edges.
- R10: While `rst_n` is low, all gate enables are off and `fault_n` and `warn_n` are high, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd_n | input | PHASES | Upper switch commands, active-low |
| lo_cmd_n | input | PHASES | Lower switch commands, active-low |
| brk_cmd_n | input | 1 | Brake switch command, active-low |
| sc_flag | input | 2*PHASES | Per-switch short-circuit flags, upper switches in the low half |
| ilim_flag | input | 1 | Over-current-limit flag |
| hi_gate | output | PHASES | Upper gate enables |
| lo_gate | output | PHASES | Lower gate enables |
| brk_gate | output | 1 | Brake gate enable |
| fault_n | output | 1 | Fault pad drive, low = fault |
| warn_n | output | 1 | Current-limit warning pad drive, low = warning |

## Verification
An interlock and a short circuit can hit the same phase in the same cycle. Both latches then hold the fault, and each of them clears under its own rule. The bench provokes this by driving both commands of one phase low together with that phase's upper short-circuit flag. It watches every cycle to confirm that neither gate of the phase ever turns on. It then releases the commands and re-issues them one at a time. The upper turn-on edge ends the short-circuit hold but leaves the interlock in place, so the upper gate must stay off and the fault must stay low. Only the later lower turn-on edge restores the gate and releases the fault.

// File: rtl/inverter_guard.sv
module inverter_guard #(
  parameter int PHASES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] hi_cmd_n,
  input  logic [PHASES-1:0] lo_cmd_n,
  input  logic              brk_cmd_n,
  input  logic [2*PHASES-1:0] sc_flag,
  input  logic              ilim_flag,
  output logic [PHASES-1:0] hi_gate,
  output logic [PHASES-1:0] lo_gate,
  output logic              brk_gate,
  output logic              fault_n,
  output logic              warn_n
);
  localparam int SW = 2 * PHASES;
  localparam int RW = SW + 1 + SW + 1;
  localparam logic [RW-1:0] IDLE = {1'b0, {SW{1'b0}}, 1'b1, {SW{1'b1}}};

  logic [RW-1:0] raw, s1, s2;
  logic [SW-1:0] on, on_q, rise, sc_s, sc_now, sc_q, blk, gate;
  logic [PHASES-1:0] hi_on, lo_on, both, fall_u, fall_l;
  logic [PHASES-1:0] il_q, fu_q, fl_q, il_clr, il_keep;
  logic brk_on, ilim_s, warn_q;

  assign raw = {ilim_flag, sc_flag, brk_cmd_n, lo_cmd_n, hi_cmd_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  assign on     = ~s2[SW-1:0];
  assign brk_on = ~s2[SW];
  assign sc_s   = s2[2*SW:SW+1];
  assign ilim_s = s2[RW-1];

  assign hi_on  = on[PHASES-1:0];
  assign lo_on  = on[SW-1:PHASES];
  assign rise   = on & ~on_q;
  assign fall_u = rise[PHASES-1:0];
  assign fall_l = rise[SW-1:PHASES];
  assign both   = hi_on & lo_on;

  assign il_clr  = il_q & ~both & ((fall_u & (fl_q | fall_l)) | (fall_l & (fu_q | fall_u)));
  assign il_keep = il_q & ~fall_u & ~fall_l;

  assign sc_now = sc_s & on;
  assign blk    = {both, both} | {il_q, il_q} | sc_q | sc_now;
  assign gate   = on & ~blk;

  assign hi_gate  = gate[PHASES-1:0];
  assign lo_gate  = gate[SW-1:PHASES];
  assign brk_gate = brk_on;
  assign fault_n  = ~(|il_q | |both | |sc_q | |sc_now);
  assign warn_n   = ~warn_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      on_q   <= '0;
      il_q   <= '0;
      fu_q   <= '0;
      fl_q   <= '0;
      sc_q   <= '0;
      warn_q <= 1'b0;
    end else begin
      on_q   <= on;
      il_q   <= both | (il_q & ~il_clr);
      fu_q   <= ~(both | il_clr) & il_q & (fu_q | fall_u);
      fl_q   <= ~(both | il_clr) & il_q & (fl_q | fall_l);
      sc_q   <= sc_now | (sc_q & ~rise);
      warn_q <= (ilim_s & |gate) | (warn_q & ~|rise);
    end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_gate & lo_gate) == '0); // R2

  AST_INTERLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (il_keep != '0) |=> ((il_q & $past(il_keep)) == $past(il_keep))); // R3

  AST_SHORT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_q != '0) |-> !fault_n); // R5

  AST_INTERLOCK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (il_q != '0) |-> !fault_n); // R3

  AST_WARN_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_n) |-> $past(|{hi_gate, lo_gate})); // R7

endmodule

// File: tb/test_inverter_guard.sv
module test_inverter_guard;
  localparam int P = 3;
  localparam int NV = 25;

  logic clk = 0, rst_n = 0;
  logic [P-1:0] hi_cmd_n = '1, lo_cmd_n = '1;
  logic brk_cmd_n = 1;
  logic [2*P-1:0] sc_flag = '0;
  logic ilim_flag = 0;
  logic [P-1:0] hi_gate, lo_gate;
  logic brk_gate, fault_n, warn_n;
  int checks = 0, errors = 0;
  bit done = 0;

  inverter_guard #(.PHASES(P)) i_inverter_guard (
    .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
    .brk_cmd_n(brk_cmd_n), .sc_flag(sc_flag), .ilim_flag(ilim_flag),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .brk_gate(brk_gate),
    .fault_n(fault_n), .warn_n(warn_n));

  always #5 clk = ~clk;

  // {req, hi_n, lo_n, brk_n, sc, ilim, exp hi, exp lo, exp brk, exp fault_n, exp warn_n}
  localparam logic [26:0] VEC [NV] = '{
    {4'd1, 3'b111, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 1'b1}, // R1 idle
    {4'd1, 3'b110, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b001, 3'b000, 1'b0, 1'b1, 1'b1},
    {4'd1, 3'b111, 3'b101, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b010, 1'b0, 1'b1, 1'b1},
    {4'd1, 3'b011, 3'b110, 1'b0, 6'b000000, 1'b0, 3'b100, 3'b001, 1'b1, 1'b1, 1'b1},
    {4'd2, 3'b110, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1}, // R2
    {4'd3, 3'b111, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1}, // R3
    {4'd3, 3'b111, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1},
    {4'd4, 3'b110, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1}, // R4 first edge
    {4'd4, 3'b111, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1},
    {4'd4, 3'b111, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b001, 1'b0, 1'b1, 1'b1}, // R4 later edge
    {4'd4, 3'b111, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 1'b1},
    {4'd5, 3'b101, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b010, 3'b001, 1'b0, 1'b1, 1'b1},
    {4'd5, 3'b101, 3'b110, 1'b1, 6'b000010, 1'b0, 3'b000, 3'b001, 1'b0, 1'b0, 1'b1}, // R5
    {4'd6, 3'b101, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b001, 1'b0, 1'b0, 1'b1}, // R6 hold
    {4'd6, 3'b111, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b001, 1'b0, 1'b0, 1'b1},
    {4'd6, 3'b101, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b010, 3'b001, 1'b0, 1'b1, 1'b1}, // R6 clear
    {4'd5, 3'b111, 3'b110, 1'b0, 6'b001000, 1'b0, 3'b000, 3'b000, 1'b1, 1'b0, 1'b1}, // R5 brake kept
    {4'd6, 3'b111, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1},
    {4'd6, 3'b111, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b001, 1'b0, 1'b1, 1'b1},
    {4'd7, 3'b111, 3'b110, 1'b1, 6'b000000, 1'b1, 3'b000, 3'b001, 1'b0, 1'b1, 1'b0}, // R7
    {4'd8, 3'b111, 3'b110, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b001, 1'b0, 1'b1, 1'b0}, // R8 hold
    {4'd8, 3'b111, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0},
    {4'd8, 3'b011, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b100, 3'b000, 1'b0, 1'b1, 1'b1}, // R8 clear
    {4'd7, 3'b111, 3'b111, 1'b1, 6'b000000, 1'b1, 3'b000, 3'b000, 1'b0, 1'b1, 1'b1}, // R7 ignored
    {4'd7, 3'b111, 3'b111, 1'b1, 6'b000000, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 1'b1}
  };

  function automatic logic [8:0] outs();
    return {hi_gate, lo_gate, brk_gate, fault_n, warn_n};
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] h, input logic [2:0] l, input logic b,
                       input logic [5:0] s, input logic i);
    hi_cmd_n = h; lo_cmd_n = l; brk_cmd_n = b; sc_flag = s; ilim_flag = i;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state with every command asking for on
    drive(3'b000, 3'b000, 1'b0, 6'b000000, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset", outs(), {3'b000, 3'b000, 1'b0, 1'b1, 1'b1});
    drive(3'b111, 3'b111, 1'b1, 6'b000000, 1'b0);
    rst_n = 1;
    settle();

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][22:20], VEC[k][19:17], VEC[k][16], VEC[k][15:10], VEC[k][9]);
      settle();
      check($sformatf("R%0d step %0d", VEC[k][26:23], k), outs(), VEC[k][8:0]);
    end

    rst_n = 0;
    drive(3'b111, 3'b111, 1'b1, 6'b000000, 1'b0);
    @(negedge clk);
    rst_n = 1;
    settle();

    // R9: two-edge latency
    hi_cmd_n = 3'b110;
    @(posedge clk); @(negedge clk);
    check("R9 after one edge", {hi_gate, 6'b0}, 9'b0);
    @(posedge clk); @(negedge clk);
    check("R9 after two edges", {hi_gate, 6'b0}, {3'b001, 6'b0});
    hi_cmd_n = 3'b111;
    settle();

    // R2 + R5: interlock and short circuit on phase 1 in the same cycle
    drive(3'b101, 3'b101, 1'b1, 6'b000010, 1'b0);
    begin
      logic seen = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (hi_gate[1] | lo_gate[1]) seen = 1;
      end
      check("R2 no gate on during joint event", {8'b0, seen}, 9'b0);
    end
    check("R5 joint event fault", outs(), {3'b000, 3'b000, 1'b0, 1'b0, 1'b1});
    drive(3'b111, 3'b111, 1'b1, 6'b000000, 1'b0);
    settle();
    check("R3 joint hold after release", outs(), {3'b000, 3'b000, 1'b0, 1'b0, 1'b1});
    hi_cmd_n = 3'b101;
    settle();
    check("R6 upper edge leaves interlock", outs(), {3'b000, 3'b000, 1'b0, 1'b0, 1'b1});
    hi_cmd_n = 3'b111;
    settle();
    lo_cmd_n = 3'b101;
    settle();
    check("R4 later lower edge clears", outs(), {3'b000, 3'b010, 1'b0, 1'b1, 1'b1});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule